// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

The block drives four pulse-width modulated outputs from a single 8-bit up-counter. All channels share this counter. A 16-bit programmable divider paces the counter. The divider itself advances only on every second system clock, so its input rate is half the clock rate. Each channel compares its own 8-bit duty value with the shared counter, and the result sets the level of that channel's output.

Software never touches the comparators directly. It writes duty values into holding registers. The hardware copies all four holding registers into the comparators when the counter rolls over from 255 to 0. A duty change made in the middle of a period therefore appears only at the start of the next period.

A control byte holds two global bits. One starts and stops the whole unit. The other inverts all four outputs together. All configuration reaches the block through a byte-wide write port.

Top module: `pwm4_unit`

## Requirements
- R1: After reset every register is 00h, the unit is stopped and all four outputs are 0.
- R2: A write with wrEn high stores wrData into the register chosen by wrAddr, effective from the next clock: 0 = control (bit 0 run, bit 1 invert), 1 = divider reload low byte, 2 = divider reload high byte, 3 to 6 = duty of channels 0 to 3.
- R3: While running with divider reload value P, the counter advances by one exactly once every 2*(P+1) clock cycles. The first advance comes 2*(P+1) cycles after the run bit takes effect, and two advances are never on consecutive cycles.
- R4: The counter is 8 bits wide, holds its value between advances, and wraps from 255 to 0.
- R5: With invert at 0, a running channel outputs 0 while its comparator value is greater than or equal to the counter, and 1 otherwise.
- R6: With invert at 1, every running output is the complement of the level defined in R5.
- R7: The comparator values are reloaded from the duty registers only when the counter wraps, so a duty write in mid-period leaves the current period unchanged.
- R8: While the run bit is 0, the counter and divider stay at zero, the comparators follow the duty registers, and every output equals the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select for the write |
| wrData | input | 8 | Write data byte |
| pwmOut | output | 4 | Modulated outputs, bit n is channel n |

## Verification
The assertions assume that reset is held at the start. They also assume the write port carries known values on every clock. They do not restrict write timing: a duty or reload write may arrive on any cycle, including the cycle of a wrap.

The random stimulus keeps every write address inside the seven defined registers. It keeps the reload value small, so that many full counter periods fit into the run. It also leaves the run bit set most of the time, so that wraps, mid-period duty writes and polarity flips all occur often.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic run;     // unit enabled
    logic tick;    // counter advance this cycle
    logic invert;  // global output polarity
  } pwmStrobe_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_PRE0 = 1;
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_INV_BIT = 1;
endpackage

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int CH     = 4,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [7:0]                wrData,
  output logic [CH-1:0][CNT_W-1:0]  dutyReg,
  output pwmStrobe_t                strobe
);
  localparam int BYTE_W    = 8;
  localparam int PRE_BYTES = PRE_W / BYTE_W;
  localparam int DUTY_BASE = ADDR_PRE0 + PRE_BYTES;

  logic                              runReg;
  logic                              invReg;
  logic [PRE_BYTES-1:0][BYTE_W-1:0]  preReg;
  logic [PRE_W-1:0]                  reloadVal;
  logic [PRE_W-1:0]                  preCnt;
  logic                              halfPhase;
  logic                              preDone;

  assign reloadVal = preReg;

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      invReg  <= 1'b0;
      preReg  <= '0;
      dutyReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_CTRL)) begin
        runReg <= wrData[CTRL_RUN_BIT];
        invReg <= wrData[CTRL_INV_BIT];
      end
      for (int b = 0; b < PRE_BYTES; b++) begin
        if (wrAddr == ADDR_W'(ADDR_PRE0 + b)) preReg[b] <= wrData;
      end
      for (int c = 0; c < CH; c++) begin
        if (wrAddr == ADDR_W'(DUTY_BASE + c)) dutyReg[c] <= wrData[CNT_W-1:0];
      end
    end
  end

  // Divider: advances on every second clock, terminal count at reload
  assign preDone = (preCnt >= reloadVal);

  always_ff @(posedge clk) begin
    if (!rstN || !runReg) begin
      halfPhase <= 1'b0;
      preCnt    <= '0;
    end else begin
      halfPhase <= ~halfPhase;
      if (halfPhase) begin
        if (preDone) preCnt <= '0;
        else         preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.run    = runReg;
    strobe.invert = invReg;
    strobe.tick   = runReg && halfPhase && preDone;
  end
endmodule

// File: rtl/pwm4_datapath.sv
module pwm4_datapath
  import pwm4_pkg::*;
#(
  parameter int CH    = 4,
  parameter int CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pwmStrobe_t                strobe,
  input  logic [CH-1:0][CNT_W-1:0]  dutyReg,
  output logic [CNT_W-1:0]          cntVal,
  output logic [CH-1:0][CNT_W-1:0]  shadowVal,
  output logic [CH-1:0]             pwmOut
);
  logic wrap;

  assign wrap = strobe.tick && (cntVal == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.run) cntVal <= '0;
    else if (strobe.tick)     cntVal <= cntVal + 1'b1;
  end

  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic rawHigh;

    always_ff @(posedge clk) begin
      if (!rstN)                     shadowVal[c] <= '0;
      else if (!strobe.run || wrap)  shadowVal[c] <= dutyReg[c];
    end

    assign rawHigh   = !(shadowVal[c] >= cntVal);
    assign pwmOut[c] = strobe.run ? (rawHigh ^ strobe.invert) : strobe.invert;
  end
endmodule

// File: rtl/pwm4_unit.sv
module pwm4_unit
  import pwm4_pkg::*;
#(
  parameter int CH     = 4,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [CH-1:0]     pwmOut
);
  pwmStrobe_t               strobe;
  logic [CH-1:0][CNT_W-1:0] dutyReg;
  logic [CH-1:0][CNT_W-1:0] shadowVal;
  logic [CNT_W-1:0]         cntVal;

  pwm4_ctrl #(.CH(CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dutyReg(dutyReg), .strobe(strobe)
  );

  pwm4_datapath #(.CH(CH), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dutyReg(dutyReg),
    .cntVal(cntVal), .shadowVal(shadowVal), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk #(
  parameter int CH    = 4,
  parameter int CNT_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     run,
  input logic                     tick,
  input logic [CNT_W-1:0]         cnt,
  input logic [CH-1:0][CNT_W-1:0] shadow
);
  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> $stable(cnt));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !(tick && cnt == {CNT_W{1'b1}})) |=> $stable(shadow));
endmodule

bind pwm4_unit pwm4_chk chk_i (
  .clk(clk), .rstN(rstN), .run(strobe.run), .tick(strobe.tick),
  .cnt(cntVal), .shadow(shadowVal)
);

// File: tb/pwm4_unit_tb.sv
module pwm4_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] pwmOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmpOn  = 0;

  always #4 clk = ~clk;

  pwm4_unit dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
                   .wrData(wrData), .pwmOut(pwmOut));

  // Reference model built from the requirements
  logic        mRun, mInv, mHalf;
  logic [15:0] mReload, mPre;
  logic [7:0]  mCnt;
  logic [7:0]  mDuty [4];
  logic [7:0]  mSh   [4];

  always @(posedge clk) begin
    if (!rstN) begin
      mRun <= 0; mInv <= 0; mHalf <= 0; mReload <= 0; mPre <= 0; mCnt <= 0;
      for (int c = 0; c < 4; c++) begin mDuty[c] <= 0; mSh[c] <= 0; end
    end else begin
      if (!mRun) begin
        mHalf <= 0; mPre <= 0; mCnt <= 0;
        for (int c = 0; c < 4; c++) mSh[c] <= mDuty[c];
      end else begin
        mHalf <= ~mHalf;
        if (mHalf) begin
          if (mPre >= mReload) begin
            mPre <= 0;
            mCnt <= mCnt + 8'd1;
            if (mCnt == 8'hFF) for (int c = 0; c < 4; c++) mSh[c] <= mDuty[c];
          end else mPre <= mPre + 16'd1;
        end
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mRun <= wrData[0]; mInv <= wrData[1]; end
          3'd1: mReload[7:0]  <= wrData;
          3'd2: mReload[15:8] <= wrData;
          3'd3, 3'd4, 3'd5, 3'd6: mDuty[wrAddr-3'd3] <= wrData;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [3:0] expOut();
    logic [3:0] r;
    for (int c = 0; c < 4; c++)
      r[c] = mRun ? (((mSh[c] >= mCnt) ? 1'b0 : 1'b1) ^ mInv) : mInv;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison of all outputs (R5, R6, R8)
  always @(negedge clk) begin
    if (rstN && cmpOn && !done)
      check(!mRun ? "R8" : (mInv ? "R6" : "R5"), {28'd0, pwmOut}, {28'd0, expOut()});
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic measure(input int ch, output int n);
    n = 0;
    while (!pwmOut[ch] && n < 4000) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int n;
    bit sawHigh;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", {28'd0, pwmOut}, 32'd0);
    cmpOn = 1;

    // R3: reload 2, counter first leaves zero after 6 cycles
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h01);
    measure(0, n);
    check("R3", n, 32'd6);

    // R8: stopped unit drives the invert level
    wr(3'd0, 8'h00);
    check("R8", {28'd0, pwmOut}, 32'h0);
    wr(3'd0, 8'h02);
    check("R8", {28'd0, pwmOut}, 32'hF);
    wr(3'd0, 8'h00);

    // R2: high reload byte at address 2, reload 256 -> 514 cycles
    wr(3'd1, 8'd0);
    wr(3'd2, 8'd1);
    wr(3'd0, 8'h01);
    measure(0, n);
    check("R2", n, 32'd514);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd0);

    // R7 and R4: reload 0, channel 1 at 80h, channel 3 at FFh
    wr(3'd4, 8'h80);
    wr(3'd6, 8'hFF);
    wr(3'd0, 8'h01);
    sawHigh = 0;
    repeat (40) begin @(negedge clk); sawHigh |= pwmOut[3]; end
    wr(3'd4, 8'h10);
    repeat (100) begin @(negedge clk); sawHigh |= pwmOut[3]; end
    check("R7", {31'd0, pwmOut[1]}, 32'd0);
    repeat (512) begin @(negedge clk); sawHigh |= pwmOut[3]; end
    check("R7", {31'd0, pwmOut[1]}, 32'd1);
    check("R4", {31'd0, sawHigh}, 32'd0);
    wr(3'd0, 8'h00);

    // Random phase (R5, R6 via the cycle compare)
    for (int i = 0; i < 300; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom % 7);
      case (a)
        3'd0: d = {6'd0, ($urandom % 2 == 1) ? 1'b1 : 1'b0, ($urandom % 10 != 0) ? 1'b1 : 1'b0};
        3'd1: d = 8'($urandom % 4);
        3'd2: d = 8'd0;
        default: begin
          case ($urandom % 6)
            0: d = 8'h00;
            1: d = 8'hFF;
            default: d = 8'($urandom);
          endcase
        end
      endcase
      wr(a, d);
      repeat (1 + $urandom % 60) @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule